// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the hardwired timing and control unit of a small 16-bit accumulator machine with 12-bit word addresses. A 4-bit step counter advances on every clock and is decoded into sixteen one-hot timing lines. The controller walks each instruction through a fixed schedule of steps: fetch, decode, optional indirect-address resolution, and execution of the seven memory-reference operations (AND, ADD, load, store, branch, branch-and-save, increment-and-skip-if-zero). It owns the address register, program counter, data register and instruction register. It drives the memory read and write enables, the 3-bit common-bus select code and the load, increment and clear strobes for those registers.

The accumulator is outside the block. The controller feeds it the data register and a one-cycle strobe per operation, and it takes the accumulator value back on `ac_in` for stores. Register-reference and input-output instructions (opcode 7) are not executed here. The controller pulses a strobe for them, presents the low 12 instruction bits, and ends the instruction. Memory is a single port. The address is always the address register. Read data for the addressed word is valid during the cycle in which the read is requested and is captured at the closing clock edge.

The step counter value is viewed as a named phase. FETCH_ADDR (T0) goes to FETCH_WORD (T1), then DECODE (T2), then RESOLVE (T3). From RESOLVE the controller returns to FETCH_ADDR for opcode 7, or goes on to EXEC_A (T4). EXEC_A returns to FETCH_ADDR for store and branch, or goes on to EXEC_B (T5). EXEC_B returns to FETCH_ADDR, except for increment-and-skip, which goes on to EXEC_C (T6) and then returns. Any other counter value clears back to FETCH_ADDR.

Top module: `instr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, the step counter is 0 and the program counter, address register, data register and instruction register are 0.
- R2: The step counter advances by one on every clock unless `sc_clr` is high, in which case it returns to 0. `tsig` is one-hot, with bit n set when `tstep` equals n.
- R3: T0 selects bus code 010 (PC) and loads the address register from the program counter. T1 asserts a memory read with bus code 111, loads the instruction register and increments the program counter. T2 loads the address register from instruction bits 11..0, latches bit 15 as the indirect flag, and decodes bits 14..12 as the opcode.
- R4: At T3 with an opcode other than 7 and the indirect flag set, one memory read (bus 111) reloads the address register from bits 11..0 of the word read. With the indirect flag clear, nothing happens at T3.
- R5: For opcode 7, T3 pulses `rr_exec` when the indirect flag is 0 or `io_exec` when it is 1, presents instruction bits 11..0 on `ir_field`, and clears the counter. The instruction takes 4 cycles.
- R6: For opcodes 0 (AND), 1 (ADD) and 2 (load), T4 reads memory into the data register. T5 pulses `ac_and`, `ac_add` or `ac_lda` respectively and clears the counter. The instruction takes 6 cycles.
- R7: For opcode 3 (store), T4 writes `ac_in` to memory at the address register with bus code 100 and clears the counter. The instruction takes 5 cycles.
- R8: For opcode 4 (branch), T4 loads the program counter from the address register with bus code 001 and clears the counter. The instruction takes 5 cycles.
- R9: For opcode 5 (branch and save), T4 writes the program counter to memory and increments the address register. T5 loads the program counter from the address register and clears the counter. The instruction takes 6 cycles.
- R10: For opcode 6 (increment and skip), T4 reads memory into the data register, T5 increments it, and T6 writes it back. At T6 the program counter also increments if the written value is zero, and the counter clears. The instruction takes 7 cycles.
- R11: Memory read is asserted only at T1, at indirect T3, and at T4 of opcodes 0, 1, 2 and 6. Memory write is asserted only at T4 of opcodes 3 and 5 and at T6 of opcode 6. Read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 16 | Memory word at `mem_addr` |
| ac_in | input | 16 | Accumulator value, stored by opcode 3 |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| bus_sel | output | 3 | Common-bus source code |
| tstep | output | 4 | Step counter value |
| tsig | output | 16 | One-hot timing lines |
| ar_ld | output | 1 | Address register load strobe |
| ar_inc | output | 1 | Address register increment strobe |
| pc_ld | output | 1 | Program counter load strobe |
| pc_inc | output | 1 | Program counter increment strobe |
| dr_ld | output | 1 | Data register load strobe |
| dr_inc | output | 1 | Data register increment strobe |
| ir_ld | output | 1 | Instruction register load strobe |
| sc_clr | output | 1 | Step counter clear |
| ac_and | output | 1 | Accumulator AND strobe |
| ac_add | output | 1 | Accumulator ADD strobe |
| ac_lda | output | 1 | Accumulator load strobe |
| rr_exec | output | 1 | Register-reference instruction strobe |
| io_exec | output | 1 | Input-output instruction strobe |
| ir_field | output | 12 | Instruction bits 11..0 |
| dr_q | output | 16 | Data register |
| pc_q | output | 12 | Program counter |
| ar_q | output | 12 | Address register |

## Verification
In the last step of increment-and-skip, the memory write-back and the conditional program-counter increment happen in the same cycle. In step T4 of branch-and-save, the memory write of the program counter and the address-register increment also coincide. The bench reaches both by sweeping every memory-reference opcode, direct and indirect, with one ordinary operand and one boundary operand. For increment-and-skip the boundary operand is 0xFFFF, so the incremented word wraps to zero. Each case is judged at the next fetch: the stored word, the program counter (advanced by two on a skip), the saved return address and the cycle count must all match values computed in the bench.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;

    typedef enum logic [2:0] {
        BUS_NONE = 3'b000,
        BUS_AR   = 3'b001,
        BUS_PC   = 3'b010,
        BUS_DR   = 3'b011,
        BUS_AC   = 3'b100,
        BUS_IR   = 3'b101,
        BUS_TR   = 3'b110,
        BUS_MEM  = 3'b111
    } bus_src_e;

    typedef enum logic [3:0] {
        PH_FETCH_ADDR = 4'd0,
        PH_FETCH_WORD = 4'd1,
        PH_DECODE     = 4'd2,
        PH_RESOLVE    = 4'd3,
        PH_EXEC_A     = 4'd4,
        PH_EXEC_B     = 4'd5,
        PH_EXEC_C     = 4'd6
    } phase_e;

    localparam int OP_AND = 0;
    localparam int OP_ADD = 1;
    localparam int OP_LDA = 2;
    localparam int OP_STA = 3;
    localparam int OP_BUN = 4;
    localparam int OP_BSA = 5;
    localparam int OP_ISZ = 6;
    localparam int OP_EXT = 7;

endpackage

// File: rtl/isc_seq_counter.sv
`timescale 1ns/1ps
module isc_seq_counter #(
    parameter int CNT_W = 4,
    localparam int NT = 1 << CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic [NT-1:0]    tdec
);

    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end

    for (genvar g = 0; g < NT; g++) begin : g_tdec
        assign tdec[g] = (count == CNT_W'(g));
    end

    // R2: advance or clear on each clock
    assert_sc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count == $past(count) + 1'b1);
    assert_sc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

endmodule

// File: rtl/isc_op_decoder.sv
`timescale 1ns/1ps
module isc_op_decoder #(
    parameter int OPC_W = 3,
    localparam int ND = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opc,
    output logic [ND-1:0]    dline
);

    for (genvar g = 0; g < ND; g++) begin : g_dline
        assign dline[g] = (opc == OPC_W'(g));
    end

endmodule

// File: rtl/instr_seq_ctrl.sv
`timescale 1ns/1ps
module instr_seq_ctrl
    import isc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int SC_W   = 4,
    parameter int OPC_W  = 3,
    localparam int NT    = 1 << SC_W,
    localparam int ND    = 1 << OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] ac_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [2:0]        bus_sel,
    output logic [SC_W-1:0]   tstep,
    output logic [NT-1:0]     tsig,
    output logic              ar_ld,
    output logic              ar_inc,
    output logic              pc_ld,
    output logic              pc_inc,
    output logic              dr_ld,
    output logic              dr_inc,
    output logic              ir_ld,
    output logic              sc_clr,
    output logic              ac_and,
    output logic              ac_add,
    output logic              ac_lda,
    output logic              rr_exec,
    output logic              io_exec,
    output logic [ADDR_W-1:0] ir_field,
    output logic [WORD_W-1:0] dr_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] ar_q
);

    localparam int OPC_LO = ADDR_W;
    localparam int IND_B  = WORD_W - 1;

    logic [WORD_W-1:0] ir_q;
    logic              ind_q;
    logic              i_ld;
    logic [ADDR_W-1:0] ar_val;
    logic [ND-1:0]     dline;
    logic              rd_op;
    bus_src_e          bus_e;
    phase_e            phase;

    isc_seq_counter #(.CNT_W(SC_W)) u_sc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sc_clr),
        .count(tstep),
        .tdec (tsig)
    );

    isc_op_decoder #(.OPC_W(OPC_W)) u_dec (
        .opc  (ir_q[OPC_LO +: OPC_W]),
        .dline(dline)
    );

    assign phase    = phase_e'(tstep);
    assign mem_addr = ar_q;
    assign ir_field = ir_q[ADDR_W-1:0];
    assign bus_sel  = bus_e;
    assign rd_op    = dline[OP_AND] | dline[OP_ADD] | dline[OP_LDA] | dline[OP_ISZ];

    // output process: strobes per phase
    always_comb begin
        mem_rd = 1'b0;  mem_wr = 1'b0;  mem_wdata = '0;
        ar_ld = 1'b0;   ar_inc = 1'b0;  ar_val = '0;
        pc_ld = 1'b0;   pc_inc = 1'b0;
        dr_ld = 1'b0;   dr_inc = 1'b0;
        ir_ld = 1'b0;   i_ld = 1'b0;    sc_clr = 1'b0;
        ac_and = 1'b0;  ac_add = 1'b0;  ac_lda = 1'b0;
        rr_exec = 1'b0; io_exec = 1'b0; bus_e = BUS_NONE;
        unique case (phase)
            PH_FETCH_ADDR: begin
                bus_e  = BUS_PC;
                ar_ld  = 1'b1;
                ar_val = pc_q;
            end
            PH_FETCH_WORD: begin
                bus_e  = BUS_MEM;
                mem_rd = 1'b1;
                ir_ld  = 1'b1;
                pc_inc = 1'b1;
            end
            PH_DECODE: begin
                bus_e  = BUS_IR;
                ar_ld  = 1'b1;
                ar_val = ir_q[ADDR_W-1:0];
                i_ld   = 1'b1;
            end
            PH_RESOLVE: begin
                if (dline[OP_EXT]) begin
                    rr_exec = ~ind_q;
                    io_exec = ind_q;
                    sc_clr  = 1'b1;
                end else if (ind_q) begin
                    bus_e  = BUS_MEM;
                    mem_rd = 1'b1;
                    ar_ld  = 1'b1;
                    ar_val = mem_rdata[ADDR_W-1:0];
                end
            end
            PH_EXEC_A: begin
                if (rd_op) begin
                    bus_e  = BUS_MEM;
                    mem_rd = 1'b1;
                    dr_ld  = 1'b1;
                end
                if (dline[OP_STA]) begin
                    bus_e     = BUS_AC;
                    mem_wr    = 1'b1;
                    mem_wdata = ac_in;
                    sc_clr    = 1'b1;
                end
                if (dline[OP_BUN]) begin
                    bus_e  = BUS_AR;
                    pc_ld  = 1'b1;
                    sc_clr = 1'b1;
                end
                if (dline[OP_BSA]) begin
                    bus_e     = BUS_PC;
                    mem_wr    = 1'b1;
                    mem_wdata = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
                    ar_inc    = 1'b1;
                end
            end
            PH_EXEC_B: begin
                ac_and = dline[OP_AND];
                ac_add = dline[OP_ADD];
                ac_lda = dline[OP_LDA];
                if (dline[OP_AND] | dline[OP_ADD] | dline[OP_LDA]) sc_clr = 1'b1;
                if (dline[OP_BSA]) begin
                    bus_e  = BUS_AR;
                    pc_ld  = 1'b1;
                    sc_clr = 1'b1;
                end
                if (dline[OP_ISZ]) dr_inc = 1'b1;
            end
            PH_EXEC_C: begin
                if (dline[OP_ISZ]) begin
                    bus_e     = BUS_DR;
                    mem_wr    = 1'b1;
                    mem_wdata = dr_q;
                    pc_inc    = (dr_q == '0);
                end
                sc_clr = 1'b1;
            end
            default: sc_clr = 1'b1;
        endcase
    end

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q  <= '0;
            pc_q  <= '0;
            dr_q  <= '0;
            ir_q  <= '0;
            ind_q <= 1'b0;
        end else begin
            if (ar_ld)       ar_q <= ar_val;
            else if (ar_inc) ar_q <= ar_q + 1'b1;
            if (pc_ld)       pc_q <= ar_q;
            else if (pc_inc) pc_q <= pc_q + 1'b1;
            if (dr_ld)       dr_q <= mem_rdata;
            else if (dr_inc) dr_q <= dr_q + 1'b1;
            if (ir_ld)       ir_q <= mem_rdata;
            if (i_ld)        ind_q <= ir_q[IND_B];
        end
    end

    assert_fetch_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH_WORD) |=> pc_q == $past(pc_q) + 1'b1);
    assert_decode_ar_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> ar_q == $past(ir_q[ADDR_W-1:0]));
    assert_indirect_ar_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESOLVE && !dline[OP_EXT] && ind_q) |=> ar_q == $past(mem_rdata[ADDR_W-1:0]));
    assert_ext_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESOLVE && dline[OP_EXT]) |=> tstep == '0);
    assert_bun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC_A && dline[OP_BUN]) |=> (pc_q == $past(ar_q) && tstep == '0));
    assert_bsa_ar_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC_A && dline[OP_BSA]) |=> ar_q == $past(ar_q) + 1'b1);
    assert_isz_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC_C && dline[OP_ISZ] && dr_q == '0) |=> pc_q == $past(pc_q) + 1'b1);
    assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_wr_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (tstep == SC_W'(4) || tstep == SC_W'(6)));

endmodule

// File: tb/sim_instr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_instr_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] mem_rdata, ac_in, mem_wdata, dr_q;
    logic [11:0] mem_addr, ir_field, pc_q, ar_q;
    logic        mem_rd, mem_wr, ar_ld, ar_inc, pc_ld, pc_inc, dr_ld, dr_inc;
    logic        ir_ld, sc_clr, ac_and, ac_add, ac_lda, rr_exec, io_exec;
    logic [2:0]  bus_sel;
    logic [3:0]  tstep;
    logic [15:0] tsig;

    logic [15:0] mem [256];
    logic [15:0] acc;
    logic        we [3];
    logic [7:0]  wa [3];
    logic [15:0] wd [3];

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    logic [11:0] pc_m;
    logic [15:0] acc_m;

    always #10 clk = ~clk;

    instr_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .ac_in(ac_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .bus_sel(bus_sel), .tstep(tstep), .tsig(tsig),
        .ar_ld(ar_ld), .ar_inc(ar_inc), .pc_ld(pc_ld), .pc_inc(pc_inc),
        .dr_ld(dr_ld), .dr_inc(dr_inc), .ir_ld(ir_ld), .sc_clr(sc_clr),
        .ac_and(ac_and), .ac_add(ac_add), .ac_lda(ac_lda),
        .rr_exec(rr_exec), .io_exec(io_exec), .ir_field(ir_field),
        .dr_q(dr_q), .pc_q(pc_q), .ar_q(ar_q)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign ac_in     = acc;

    // bench memory and accumulator model
    always @(posedge clk) begin
        for (int k = 0; k < 3; k++) if (we[k]) mem[wa[k]] <= wd[k];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (!rst_n)      acc <= 16'h0F3C;
        else if (ac_and) acc <= acc & dr_q;
        else if (ac_add) acc <= acc + dr_q;
        else if (ac_lda) acc <= dr_q;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_insn(input int op, input bit ind, input logic [15:0] val);
        logic [11:0] a, t, ea, exp_pc;
        logic [15:0] exp_acc, exp_mem, sum;
        int cyc, rd, wr, cnt, rdc, wrc, rrc, ioc;
        bit seq_ok, t0ok, t1ok, ar3ok, ar4ok;
        logic [11:0] fld;
        string tag;
        a  = pc_m + 12'h011;
        t  = pc_m + 12'h023;
        ea = ind ? t : a;
        exp_pc = pc_m + 12'd1; exp_acc = acc_m; exp_mem = val; wr = 0;
        case (op)
            0: begin tag = "R6"; cyc = 6; rd = 2; exp_acc = acc_m & val; end
            1: begin tag = "R6"; cyc = 6; rd = 2; exp_acc = acc_m + val; end
            2: begin tag = "R6"; cyc = 6; rd = 2; exp_acc = val; end
            3: begin tag = "R7"; cyc = 5; rd = 1; wr = 1; exp_mem = acc_m; end
            4: begin tag = "R8"; cyc = 5; rd = 1; exp_pc = ea; end
            5: begin tag = "R9"; cyc = 6; rd = 1; wr = 1;
                     exp_mem = {4'h0, pc_m + 12'd1}; exp_pc = ea + 12'd1; end
            6: begin tag = "R10"; cyc = 7; rd = 2; wr = 1; sum = val + 16'd1;
                     exp_mem = sum; exp_pc = (sum == 16'd0) ? pc_m + 12'd2 : pc_m + 12'd1; end
            default: begin tag = "R5"; cyc = 4; rd = 1; end
        endcase
        if (op != 7 && ind) rd = rd + 1;
        // place instruction, pointer and operand while the DUT sits in T0
        we[0] = 1'b1; wa[0] = pc_m[7:0]; wd[0] = {ind, 3'(op), a};
        we[1] = ind;  wa[1] = a[7:0];    wd[1] = {4'h0, t};
        we[2] = (op != 7); wa[2] = ea[7:0]; wd[2] = val;
        cnt = 0; rdc = 0; wrc = 0; rrc = 0; ioc = 0; fld = '0;
        seq_ok = 1; t0ok = 0; t1ok = 0; ar3ok = 1; ar4ok = 1;
        do begin
            if (tstep != 4'(cnt) || tsig != (16'd1 << cnt)) seq_ok = 0;
            if (cnt == 0) t0ok = (bus_sel == 3'b010) && ar_ld;
            if (cnt == 1) t1ok = mem_rd && (bus_sel == 3'b111) && ir_ld && pc_inc;
            if (cnt == 3) ar3ok = (ar_q == a);
            if (cnt == 4 && op != 7) ar4ok = (ar_q == ea);
            rdc += int'(mem_rd);
            wrc += int'(mem_wr);
            rrc += int'(rr_exec);
            ioc += int'(io_exec);
            if (rr_exec || io_exec) fld = ir_field;
            cnt++;
            @(negedge clk);
            if (cnt == 1) begin we[0] = 1'b0; we[1] = 1'b0; we[2] = 1'b0; end
        end while (tstep != 4'd0 && cnt < 20);
        chk("R2", "step sequence", 32'(seq_ok), 32'd1);
        chk("R3", "T0/T1 controls", 32'({t0ok, t1ok}), 32'b11);
        chk("R3", "AR from IR at T2", 32'(ar3ok), 32'd1);
        chk("R4", "AR after T3", 32'(ar4ok), 32'd1);
        chk(tag, "cycle count", 32'(cnt), 32'(cyc));
        chk("R11", "read count", 32'(rdc), 32'(rd));
        chk("R11", "write count", 32'(wrc), 32'(wr));
        chk(tag, "next PC", 32'(pc_q), 32'(exp_pc));
        if (op <= 2) chk("R6", "accumulator", 32'(acc), 32'(exp_acc));
        if (op == 3 || op == 5 || op == 6)
            chk(tag, "memory word", 32'(mem[ea[7:0]]), 32'(exp_mem));
        if (op == 7) begin
            chk("R5", "rr/io strobes", 32'({rrc[3:0], ioc[3:0]}), ind ? 32'h01 : 32'h10);
            chk("R5", "ir_field", 32'(fld), 32'(a));
        end
        pc_m  = pc_q;
        acc_m = acc;
    endtask

    initial begin
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin we[k] = 1'b0; wa[k] = '0; wd[k] = '0; end
        repeat (3) @(negedge clk);
        chk("R1", "reset step", 32'(tstep), 32'd0);
        chk("R1", "reset PC/AR", 32'({pc_q, ar_q}), 32'd0);
        chk("R1", "reset DR", 32'(dr_q), 32'd0);
        chk("R2", "reset timing line", 32'(tsig), 32'd1);
        rst_n = 1'b1;
        pc_m  = '0;
        acc_m = 16'h0F3C;
        for (int op = 0; op < 7; op++)
            for (int ind = 0; ind < 2; ind++)
                for (int pat = 0; pat < 2; pat++)
                    run_insn(op, ind[0],
                        pat == 1 ? ((op == 6) ? 16'hFFFF : 16'h8001)
                                 : 16'h5A3C ^ 16'(op * 16'h0F11 + ind * 16'h0303));
        run_insn(7, 1'b0, 16'h0);
        run_insn(7, 1'b1, 16'h0);
        run_insn(6, 1'b0, 16'hFFFF);
        run_insn(5, 1'b1, 16'h1234);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule